// File: doc/BRIEF.md
# Priority-Threshold Interrupt Controller

This block collects a set of interrupt request inputs and records a rising edge on each one as a pending bit. It combines those pending bits into one registered processor interrupt line. Software reaches the block through a single-cycle, word-addressed register port. Through that port it reads the pending bits, masks sources individually, clears serviced sources by writing ones, and opens or closes a master gate.

A threshold register supports nested interrupt handling. Source 0 has the highest priority, and higher indices have progressively lower priority. While the threshold holds N, only sources with an index below N can drive the interrupt line. A handler can therefore raise the threshold to its own index, which holds back everything of equal or lower priority until it restores the old value. The threshold never touches the pending bits. A source that was held back is still pending when the threshold opens again, and it then asserts the line.

The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the pending, enable and master-gate registers read zero, the threshold register reads all ones (LVL_W bits, zero-extended on read), and `irq_o` is low.
- R2: A low-to-high transition of `src_i[i]` sets pending bit i, which is readable at word address 0 (bit i = source i). A source held high does not set the bit again once it has been cleared. Writes to word 0 have no effect.
- R3: Writing to word address 3 clears every pending bit whose data bit is 1. A new rising edge in the same cycle keeps its bit set. Word 3 reads zero.
- R4: The per-source enable register at word address 2 (bit i = source i) and the master gate at word address 7, bit 0, must both be set for a source to reach `irq_o`.
- R5: `irq_o` is registered. It equals the OR over all sources that are pending, enabled and below the threshold, gated by the master bit, and it reflects any input change or register write on the next clock.
- R6: The threshold register at word address 9 holds value N, and source i may drive `irq_o` only when i < N. A value of 0 blocks every source, and a value of 1 passes source 0 only.
- R7: A write to the threshold register leaves all pending bits unchanged. A pending, enabled source that was blocked asserts `irq_o` on the clock after the threshold is raised above its index.
- R8: A threshold of all ones (or any value of at least NUM_SRC) blocks no source.
- R9: Reads from any word address other than 0, 2, 3, 7 and 9 return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address for read and write |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, same cycle |
| src_i | input | NUM_SRC | Interrupt request inputs, edge-sensitive |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The bench builds the controller with NUM_SRC = 8, which makes LVL_W 4 and the all-ones threshold 15. It can therefore walk every threshold value from 0 through NUM_SRC and beyond, including the value equal to the source count, and observe the boundary source on each side. With eight sources, a same-cycle acknowledge and rising edge and a source held high through its own acknowledge can be placed on chosen bits, and the outcome can be read back through the status word.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  // Word addresses of the register port
  localparam int unsigned STAT_WORD = 0;
  localparam int unsigned EN_WORD   = 2;
  localparam int unsigned ACK_WORD  = 3;
  localparam int unsigned MST_WORD  = 7;
  localparam int unsigned LVL_WORD  = 9;
endpackage

// File: rtl/pic_edge_latch.sv
module pic_edge_latch #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] ack_mask,
  output logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] pend_d
);
  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] rise;

  always_comb begin
    rise   = src_i & ~prev_q;
    pend_d = (pend_q & ~ack_mask) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= src_i;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/pic_regfile.sv
module pic_regfile
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned LVL_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] en_d,
  output logic               mst_q,
  output logic               mst_d,
  output logic [LVL_W-1:0]   lvl_q,
  output logic [LVL_W-1:0]   lvl_d,
  output logic [NUM_SRC-1:0] ack_mask,
  output logic [DATA_W-1:0]  rdata
);
  logic hit_en, hit_ack, hit_mst, hit_lvl;

  always_comb begin
    hit_en   = wr_en && (addr == ADDR_W'(EN_WORD));
    hit_ack  = wr_en && (addr == ADDR_W'(ACK_WORD));
    hit_mst  = wr_en && (addr == ADDR_W'(MST_WORD));
    hit_lvl  = wr_en && (addr == ADDR_W'(LVL_WORD));
    en_d     = hit_en  ? wdata[NUM_SRC-1:0] : en_q;
    mst_d    = hit_mst ? wdata[0]           : mst_q;
    lvl_d    = hit_lvl ? wdata[LVL_W-1:0]   : lvl_q;
    ack_mask = hit_ack ? wdata[NUM_SRC-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      mst_q <= 1'b0;
      lvl_q <= '1;
    end else begin
      en_q  <= en_d;
      mst_q <= mst_d;
      lvl_q <= lvl_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(STAT_WORD))     rdata[NUM_SRC-1:0] = pend_q;
    else if (addr == ADDR_W'(EN_WORD))  rdata[NUM_SRC-1:0] = en_q;
    else if (addr == ADDR_W'(MST_WORD)) rdata[0]           = mst_q;
    else if (addr == ADDR_W'(LVL_WORD)) rdata[LVL_W-1:0]   = lvl_q;
  end
endmodule

// File: rtl/pic_irq_gen.sv
module pic_irq_gen #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned LVL_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend_d,
  input  logic [NUM_SRC-1:0] en_d,
  input  logic               mst_d,
  input  logic [LVL_W-1:0]   lvl_d,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] below;
  logic               irq_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_thr
    assign below[i] = (lvl_d > LVL_W'(i));
  end

  always_comb irq_d = mst_d & (|(pend_d & en_d & below));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_d;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  localparam int unsigned LVL_W  = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o
);
  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic [NUM_SRC-1:0] pend_q, pend_d, en_q, en_d, ack_mask;
  logic               mst_q, mst_d;
  logic [LVL_W-1:0]   lvl_q, lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  pic_edge_latch #(.NUM_SRC(NUM_SRC)) u_latch (
    .clk(clk), .rst_n(rst_sync_n), .src_i(src_i), .ack_mask(ack_mask),
    .pend_q(pend_q), .pend_d(pend_d)
  );

  pic_regfile #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pend_q(pend_q), .en_q(en_q), .en_d(en_d), .mst_q(mst_q), .mst_d(mst_d),
    .lvl_q(lvl_q), .lvl_d(lvl_d), .ack_mask(ack_mask), .rdata(rdata)
  );

  pic_irq_gen #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_irq (
    .clk(clk), .rst_n(rst_sync_n), .pend_d(pend_d), .en_d(en_d),
    .mst_d(mst_d), .lvl_d(lvl_d), .irq_o(irq_o)
  );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned LVL_W   = 6
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic [DATA_W-1:0]  rdata,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic               mst_q,
  input logic [LVL_W-1:0]   lvl_q
);
  logic mapped;
  assign mapped = (addr == ADDR_W'(STAT_WORD)) || (addr == ADDR_W'(EN_WORD)) ||
                  (addr == ADDR_W'(ACK_WORD))  || (addr == ADDR_W'(MST_WORD)) ||
                  (addr == ADDR_W'(LVL_WORD));

  // R4
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mst_q |-> !irq_o);
  // R6
  level_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lvl_q == '0) |-> !irq_o);
  // R6
  level_one_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((lvl_q == LVL_W'(1)) && irq_o) |-> (pend_q[0] && en_q[0]));
  // R5
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o |-> (|(pend_q & en_q)));
  // R7
  level_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == ADDR_W'(LVL_WORD)) |=> (lvl_q == $past(wdata[LVL_W-1:0])));
  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mapped |-> (rdata == '0));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .irq_o(irq_o), .pend_q(pend_q), .en_q(en_q), .mst_q(mst_q),
  .lvl_q(lvl_q)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int NS = 8;
  logic        clk, rst_n, wr_en, irq_o;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic [NS-1:0] src_i;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [NS-1:0] m_pend, m_en, m_prev;
  logic          m_mst, m_irq;
  logic [3:0]    m_lvl;

  prio_irq_ctrl #(.NUM_SRC(NS), .DATA_W(32), .ADDR_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .src_i(src_i), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return {24'd0, m_pend};
      4'd2: return {24'd0, m_en};
      4'd7: return {31'd0, m_mst};
      4'd9: return {28'd0, m_lvl};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check();
    logic [31:0] er;
    er = m_read(addr);
    n_cmp++;
    if (irq_o !== m_irq) begin
      n_bad++;
      $display("FAIL %s irq_o actual=%b expected=%b t=%0t", cur_req, irq_o, m_irq, $time);
    end
    n_cmp++;
    if (rdata !== er) begin
      n_bad++;
      $display("FAIL %s rdata@%0d actual=%h expected=%h t=%0t", cur_req, addr, rdata, er, $time);
    end
  endtask

  task automatic model_step(input bit w, input logic [3:0] a, input logic [31:0] d,
                            input logic [NS-1:0] s);
    logic [NS-1:0] ack, gate;
    ack = (w && a == 4'd3) ? d[NS-1:0] : '0;
    m_pend = (m_pend & ~ack) | (s & ~m_prev);
    m_prev = s;
    if (w && a == 4'd2) m_en  = d[NS-1:0];
    if (w && a == 4'd7) m_mst = d[0];
    if (w && a == 4'd9) m_lvl = d[3:0];
    for (int i = 0; i < NS; i++) gate[i] = (i < int'(m_lvl));
    m_irq = m_mst && ((m_pend & m_en & gate) != 0);
  endtask

  // one cycle: check at negedge, drive, model follows the edge
  task automatic cyc(input bit w, input logic [3:0] a, input logic [31:0] d,
                     input logic [NS-1:0] s);
    check();
    wr_en = w; addr = a; wdata = d; src_i = s;
    @(posedge clk);
    model_step(w, a, d, s);
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, input logic [NS-1:0] s);
    cyc(1'b0, a, 32'd0, s);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [NS-1:0] s);
    cyc(1'b1, a, d, s);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; src_i = '0;
    m_pend = '0; m_en = '0; m_prev = '0; m_mst = 1'b0; m_irq = 1'b0; m_lvl = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values through the port
    cur_req = "R1";
    rd(4'd0, '0); rd(4'd2, '0); rd(4'd7, '0); rd(4'd9, '0); rd(4'd3, '0); rd(4'd9, '0);

    // R2 / R4 / R5: edge, enable and master gating
    cur_req = "R2";
    rd(4'd0, 8'h08); rd(4'd0, 8'h08); wr(4'd0, 32'hFF, 8'h08); rd(4'd0, 8'h08);
    cur_req = "R4";
    wr(4'd2, 32'h08, 8'h08); rd(4'd0, 8'h08);
    cur_req = "R5";
    wr(4'd7, 32'h1, 8'h00); rd(4'd7, 8'h00);
    cur_req = "R4";
    wr(4'd7, 32'h0, 8'h00); rd(4'd0, 8'h00); wr(4'd7, 32'h1, 8'h00); rd(4'd2, 8'h00);
    wr(4'd2, 32'h00, 8'h00); rd(4'd0, 8'h00);
    wr(4'd2, 32'hFF, 8'h00);

    // R6 / R7: threshold blocks source 3, pending kept, released on raise
    cur_req = "R6";
    wr(4'd9, 32'h3, 8'h00); rd(4'd0, 8'h00);
    cur_req = "R7";
    rd(4'd0, 8'h00); wr(4'd9, 32'h4, 8'h00); rd(4'd0, 8'h00);
    cur_req = "R6";
    wr(4'd9, 32'h0, 8'h01); rd(4'd0, 8'h01); wr(4'd9, 32'h1, 8'h01); rd(4'd0, 8'h01);
    wr(4'd3, 32'h01, 8'h01); rd(4'd0, 8'h01);
    for (int v = 0; v <= 9; v++) begin
      wr(4'd9, 32'(v), 8'h00); rd(4'd0, 8'h00);
    end
    wr(4'd3, 32'hFF, 8'h00);
    rd(4'd0, 8'h80); wr(4'd9, 32'h7, 8'h80); rd(4'd0, 8'h80);
    wr(4'd9, 32'h8, 8'h80); rd(4'd9, 8'h80);
    // R8: all ones opens every source
    cur_req = "R8";
    wr(4'd9, 32'hF, 8'h80); rd(4'd0, 8'h80); rd(4'd9, 8'h80);

    // R3: acknowledge, same-cycle rise wins, held source does not re-pend
    cur_req = "R3";
    wr(4'd3, 32'hFF, 8'h80); rd(4'd0, 8'h80); rd(4'd0, 8'h00);
    wr(4'd3, 32'h20, 8'h20); rd(4'd0, 8'h20);
    wr(4'd3, 32'h20, 8'h20); rd(4'd0, 8'h20); rd(4'd3, 8'h00);
    cur_req = "R2";
    rd(4'd0, 8'h00); rd(4'd0, 8'h20);

    // R9: unmapped addresses
    cur_req = "R9";
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 2 && a != 3 && a != 7 && a != 9) begin
        wr(4'(a), 32'hFFFF_FFFF, 8'h00); rd(4'(a), 8'h00);
      end
    end
    rd(4'd2, 8'h00); rd(4'd7, 8'h00); rd(4'd9, 8'h00); rd(4'd0, 8'h00);
    wr(4'd3, 32'hFF, 8'h00); rd(4'd0, 8'h00); rd(4'd0, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule